// File: doc/BRIEF.md
# SPI Slave Wake-Up and Configuration Controller

This block sits behind the register port of a generic SPI slave, on the device side. It keeps the host-visible function-0 settings: transfer word size, byte order, sampling-edge scheme, the active level of the interrupt line, and the read turnaround delay. The settings drive the serial engine through dedicated outputs. A fixed identification byte lets a host poll the device after power-up and tell that reset has ended.

Waking the device is a two-step handshake. The host writes a 1 to the wake bit. The block then raises a clock request toward the power manager and holds it until the power manager answers with clock-ready. When the handshake completes, a ready event is latched as pending. The event drives the interrupt line at the level that the polarity setting selects, and it stays until the host clears it through the status register. The serial shifter is replaced here by a simple strobed register port, with registered read data.

Top module: `spi_wake_cfg`

## Requirements
- R1: After reset, config register 0x00 reads 0x30 (same-edge and active-high set, everything else clear), delay register 0x01 reads 0x04, status 0x02 reads 0x00, and `clk_req` and `host_irq` are low.
- R2: Config register 0x00 has these fields: bit 0 selects the word size (1 = 32-bit), bit 1 selects the byte order (1 = big endian), bit 4 selects the edge scheme (1 = same edge), bit 5 sets the interrupt polarity (1 = active high), and bit 7 is the wake bit. All of them read back as written, and bits 0, 1 and 4 drive `cfg_word32`, `cfg_big_endian` and `cfg_same_edge`. The other bits read as 0.
- R3: Register 0x01 is an 8-bit read/write delay, counted in units of 8 bits, and it appears on `cfg_resp_delay`.
- R4: Address 0x14 always reads `ID_BYTE` (default 0xA5). Writes to it have no effect.
- R5: Writing 0x00 with bit 7 = 1 raises `clk_req` on the next cycle. `clk_req` stays high until a cycle in which `clk_ready` is high, and then it falls.
- R6: Writing 0x00 with bit 7 = 0 drops `clk_req` on the next cycle, even if `clk_ready` never came.
- R7: A cycle with both `clk_req` and `clk_ready` high sets the ready-pending flag. The flag reads as bit 0 of status register 0x02.
- R8: `host_irq` equals the pending flag when polarity is 1 and its inverse when polarity is 0. It follows the new settings on the cycle after the write.
- R9: Writing 0x02 with bit 0 = 1 clears the pending flag. If a handshake completes in the same cycle, the set wins and the flag stays 1.
- R10: Reads of any address other than 0x00, 0x01, 0x02 and 0x14 return 0, and writes to them change nothing.
- R11: `reg_rdata` takes a new value one cycle after a `reg_rd_en` strobe and holds it until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| clk_ready | input | 1 | Clock-available answer from the power manager |
| clk_req | output | 1 | Clock request toward the power manager |
| host_irq | output | 1 | Ready interrupt, level set by polarity |
| cfg_word32 | output | 1 | Word size select |
| cfg_big_endian | output | 1 | Byte order select |
| cfg_same_edge | output | 1 | Edge scheme select |
| cfg_resp_delay | output | 8 | Read turnaround delay |

## Verification
Two functions can collide in one cycle: the host's write-1-to-clear on status, and the power manager's clock-ready answer that completes a pending request. The bench arranges this by leaving the pending flag set, issuing a new wake request, and then driving the clear write and `clk_ready` in the same cycle. It passes when the interrupt stays asserted and status still reads 1 while `clk_req` falls, and when a second, lone clear then drops the interrupt.

// File: rtl/spi_wake_pkg.sv
package spi_wake_pkg;
  localparam logic [7:0] ADDR_CFG  = 8'h00;
  localparam logic [7:0] ADDR_DLY  = 8'h01;
  localparam logic [7:0] ADDR_STAT = 8'h02;
  localparam logic [7:0] ADDR_ID   = 8'h14;

  localparam int BIT_W32  = 0;
  localparam int BIT_BE   = 1;
  localparam int BIT_EDGE = 4;
  localparam int BIT_POL  = 5;
  localparam int BIT_WAKE = 7;

  typedef struct packed {
    logic wake;
    logic pol;
    logic same_edge;
    logic big_endian;
    logic word32;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{wake: 1'b0, pol: 1'b1, same_edge: 1'b1,
                                 big_endian: 1'b0, word32: 1'b0};

  function automatic logic [7:0] cfg_to_byte(cfg_t c);
    logic [7:0] b;
    b = '0;
    b[BIT_W32]  = c.word32;
    b[BIT_BE]   = c.big_endian;
    b[BIT_EDGE] = c.same_edge;
    b[BIT_POL]  = c.pol;
    b[BIT_WAKE] = c.wake;
    return b;
  endfunction

  function automatic cfg_t byte_to_cfg(logic [7:0] b);
    cfg_t c;
    c.word32     = b[BIT_W32];
    c.big_endian = b[BIT_BE];
    c.same_edge  = b[BIT_EDGE];
    c.pol        = b[BIT_POL];
    c.wake       = b[BIT_WAKE];
    return c;
  endfunction
endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_wake_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] DLY_RESET = 8'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cfg,
  input  logic              wr_dly,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg_q,
  output cfg_t              cfg_next,
  output logic [DATA_W-1:0] dly_q
);
  always_comb begin
    cfg_next = cfg_q;
    if (wr_cfg) cfg_next = byte_to_cfg(wdata[7:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
      dly_q <= DLY_RESET;
    end else begin
      cfg_q <= cfg_next;
      if (wr_dly) dly_q <= wdata;
    end
  end
endmodule

// File: rtl/spi_wake_ctrl.sv
module spi_wake_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_cfg,
  input  logic wake_val,
  input  logic clr_pend,
  input  logic clk_ready,
  input  logic pol_next,
  output logic clk_req,
  output logic pend,
  output logic irq
);
  logic done;
  logic req_n;
  logic pend_n;

  assign done = clk_req & clk_ready;

  always_comb begin
    req_n = clk_req & ~clk_ready;
    if (wr_cfg) req_n = wake_val;
    pend_n = pend;
    if (clr_pend) pend_n = 1'b0;
    if (done)     pend_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_req <= 1'b0;
      pend    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      clk_req <= req_n;
      pend    <= pend_n;
      irq     <= pol_next ? pend_n : ~pend_n;
    end
  end
endmodule

// File: rtl/spi_rd_mux.sv
module spi_rd_mux
  import spi_wake_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ID_BYTE = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  cfg_t              cfg,
  input  logic [DATA_W-1:0] dly,
  input  logic              pend,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == ADDR_W'(ADDR_CFG))       sel = cfg_to_byte(cfg);
    else if (addr == ADDR_W'(ADDR_DLY))  sel = dly;
    else if (addr == ADDR_W'(ADDR_STAT)) sel = {{(DATA_W-1){1'b0}}, pend};
    else if (addr == ADDR_W'(ADDR_ID))   sel = ID_BYTE;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end
endmodule

// File: rtl/spi_wake_cfg.sv
module spi_wake_cfg
  import spi_wake_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [7:0] ID_BYTE = 8'hA5,
  parameter logic [7:0] DLY_RESET = 8'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              clk_ready,
  output logic              clk_req,
  output logic              host_irq,
  output logic              cfg_word32,
  output logic              cfg_big_endian,
  output logic              cfg_same_edge,
  output logic [7:0]        cfg_resp_delay
);
  logic wr_cfg, wr_dly, wr_stat;
  cfg_t cfg_q, cfg_next;
  logic [7:0] dly_q;
  logic pend_q;

  assign wr_cfg  = reg_wr_en && (reg_addr == ADDR_W'(ADDR_CFG));
  assign wr_dly  = reg_wr_en && (reg_addr == ADDR_W'(ADDR_DLY));
  assign wr_stat = reg_wr_en && (reg_addr == ADDR_W'(ADDR_STAT));

  spi_cfg_regs #(.DATA_W(8), .DLY_RESET(DLY_RESET)) u_regs (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wr_dly(wr_dly),
    .wdata(reg_wdata), .cfg_q(cfg_q), .cfg_next(cfg_next), .dly_q(dly_q)
  );

  spi_wake_ctrl u_wake (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wake_val(reg_wdata[BIT_WAKE]),
    .clr_pend(wr_stat && reg_wdata[0]), .clk_ready(clk_ready),
    .pol_next(cfg_next.pol), .clk_req(clk_req), .pend(pend_q), .irq(host_irq)
  );

  spi_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(8), .ID_BYTE(ID_BYTE)) u_rd (
    .clk(clk), .rst(rst), .rd_en(reg_rd_en), .addr(reg_addr),
    .cfg(cfg_q), .dly(dly_q), .pend(pend_q), .rdata(reg_rdata)
  );

  assign cfg_word32     = cfg_q.word32;
  assign cfg_big_endian = cfg_q.big_endian;
  assign cfg_same_edge  = cfg_q.same_edge;
  assign cfg_resp_delay = dly_q;
endmodule

// File: rtl/spi_wake_cfg_chk.sv
module spi_wake_cfg_chk
  import spi_wake_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [7:0] ID_BYTE = 8'hA5
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              clk_ready,
  input logic              clk_req,
  input logic              pend
);
  logic cfg_hit, mapped;
  assign cfg_hit = reg_wr_en && (reg_addr == ADDR_W'(ADDR_CFG));
  assign mapped  = (reg_addr == ADDR_W'(ADDR_CFG)) || (reg_addr == ADDR_W'(ADDR_DLY)) ||
                   (reg_addr == ADDR_W'(ADDR_STAT)) || (reg_addr == ADDR_W'(ADDR_ID));

  // R5
  wake_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_hit && reg_wdata[BIT_WAKE]) |=> clk_req);
  // R5
  req_release_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_req && clk_ready && !cfg_hit) |=> !clk_req);
  // R6
  wake_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_hit && !reg_wdata[BIT_WAKE]) |=> !clk_req);
  // R7
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_req && clk_ready) |=> pend);
  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == ADDR_W'(ADDR_STAT) && reg_wdata[0] && !(clk_req && clk_ready))
    |=> !pend);
  // R4
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr == ADDR_W'(ADDR_ID)) |=> (reg_rdata == ID_BYTE));
  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && !mapped) |=> (reg_rdata == 8'h00));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_en |=> $stable(reg_rdata));
endmodule

bind spi_wake_cfg spi_wake_cfg_chk #(.ADDR_W(ADDR_W), .ID_BYTE(ID_BYTE)) u_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .clk_ready(clk_ready), .clk_req(clk_req), .pend(pend_q)
);

// File: tb/spi_wake_cfg_test.sv
module spi_wake_cfg_test;
  logic clk = 0, rst = 1;
  logic wr = 0, rd = 0, rdy = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata, dly;
  logic req, irq, w32, be, se;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_wake_cfg uut (
    .clk(clk), .rst(rst), .reg_wr_en(wr), .reg_rd_en(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .clk_ready(rdy), .clk_req(req),
    .host_irq(irq), .cfg_word32(w32), .cfg_big_endian(be), .cfg_same_edge(se),
    .cfg_resp_delay(dly)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd = 1;
    @(negedge clk); rd = 0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 req", {7'd0, req}, 0);
    chk("R1 irq", {7'd0, irq}, 0);
    rd_reg(8'h00, v); chk("R1 cfg", v, 8'h30);
    rd_reg(8'h01, v); chk("R1 dly", v, 8'h04);
    rd_reg(8'h02, v); chk("R1 stat", v, 8'h00);
    chk("R1 outs", {5'd0, w32, be, se}, 8'h01);
  endtask

  task automatic t_fields;
    logic [7:0] v;
    wr_reg(8'h00, 8'h23);
    rd_reg(8'h00, v); chk("R2 readback", v, 8'h23);
    chk("R2 outs", {5'd0, w32, be, se}, 8'h06);
    wr_reg(8'h00, 8'h7F);
    rd_reg(8'h00, v); chk("R2 masked", v, 8'h33);
    wr_reg(8'h00, 8'h30);
    wr_reg(8'h01, 8'hC9);
    rd_reg(8'h01, v); chk("R3 delay", v, 8'hC9);
    chk("R3 port", dly, 8'hC9);
  endtask

  task automatic t_id_unmapped;
    logic [7:0] v;
    wr_reg(8'h14, 8'h00);
    rd_reg(8'h14, v); chk("R4 id", v, 8'hA5);
    wr_reg(8'h07, 8'hFF);
    rd_reg(8'h07, v); chk("R10 unmapped", v, 8'h00);
    rd_reg(8'h00, v); chk("R10 cfg intact", v, 8'h30);
    rd_reg(8'h01, v); chk("R10 dly intact", v, 8'hC9);
    chk("R10 req", {7'd0, req}, 0);
  endtask

  task automatic t_readhold;
    logic [7:0] v;
    addr = 8'h01; rd = 1;
    @(posedge clk); #1;
    chk("R11 after edge", rdata, 8'hC9);
    @(negedge clk); rd = 0; addr = 8'h14;
    @(negedge clk); @(negedge clk);
    chk("R11 hold", rdata, 8'hC9);
  endtask

  task automatic t_wake;
    logic [7:0] v;
    wr_reg(8'h00, 8'hB0);
    chk("R5 req up", {7'd0, req}, 1);
    repeat (3) @(negedge clk);
    chk("R5 req held", {7'd0, req}, 1);
    chk("R7 irq idle", {7'd0, irq}, 0);
    rdy = 1; @(negedge clk); rdy = 0;
    chk("R5 req down", {7'd0, req}, 0);
    chk("R7 irq up", {7'd0, irq}, 1);
    rd_reg(8'h02, v); chk("R7 stat", v, 8'h01);
    rd_reg(8'h00, v); chk("R2 wake readback", v, 8'hB0);
  endtask

  task automatic t_polarity;
    wr_reg(8'h00, 8'h10);
    chk("R8 low pend1", {7'd0, irq}, 0);
    wr_reg(8'h02, 8'h01);
    chk("R8 low pend0", {7'd0, irq}, 1);
    wr_reg(8'h00, 8'h30);
    chk("R8 high pend0", {7'd0, irq}, 0);
  endtask

  task automatic t_drop;
    wr_reg(8'h00, 8'hB0);
    chk("R6 up", {7'd0, req}, 1);
    wr_reg(8'h00, 8'h30);
    chk("R6 dropped", {7'd0, req}, 0);
    rdy = 1; @(negedge clk); rdy = 0;
    chk("R6 no pend", {7'd0, irq}, 0);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    wr_reg(8'h00, 8'hB0);
    rdy = 1; @(negedge clk); rdy = 0;
    chk("R9 pend set", {7'd0, irq}, 1);
    wr_reg(8'h00, 8'hB0);
    addr = 8'h02; wdata = 8'h01; wr = 1; rdy = 1;
    @(negedge clk); wr = 0; rdy = 0;
    chk("R9 set wins irq", {7'd0, irq}, 1);
    chk("R9 req done", {7'd0, req}, 0);
    rd_reg(8'h02, v); chk("R9 stat", v, 8'h01);
    wr_reg(8'h02, 8'h01);
    chk("R9 cleared", {7'd0, irq}, 0);
    rd_reg(8'h02, v); chk("R9 stat clr", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_fields();
    t_id_unmapped();
    t_readhold();
    t_wake();
    t_polarity();
    t_drop();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule